// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast clock by a programmable ratio of M*N + A and raises one output pulse, one input clock wide, at the end of every full count. It is the feedback path of a frequency synthesizer loop. A dual-modulus prescaler divides by M+1 for the first A of its periods. It divides by M for the rest. A main counter ends the output cycle after N prescaler periods. The result is a fine-grained total ratio built from two short counters.

The prescaler pair is fixed at build time by a band parameter. The low band uses 8 or 16. The high band uses 64 or 128. A modulus-select input picks between the two values. The prescaler is modelled as synchronous logic on the divided clock itself. N, A and the modulus select are sampled only where one output cycle ends and the next begins, so a running cycle always completes with the settings it started with. Dropping the enable puts the block in a power-save state. In that state the counters are cleared and the output stays low. Raising the enable again starts a fresh cycle from zero.

Top module: `pswallow_div`

## Requirements
- R1: With HIGH_BAND = 0, consecutive output pulses are exactly M*N + A input clocks apart, where M = 8 when msel_i = 1 and M = 16 when msel_i = 0.
- R2: With HIGH_BAND = 1, the pulse spacing is M*N + A with M = 64 when msel_i = 1 and M = 128 when msel_i = 0.
- R3: The first A prescaler periods of an output cycle last M+1 clocks and the remaining N-A last M clocks, so the spacing holds at both swallow extremes A = 0 and A = N-1 (legal range A < N, A <= 127).
- R4: pulse_o is high for exactly one input clock per output cycle.
- R5: n_i, a_i and msel_i are sampled only on the clock edge that ends an output cycle (or starts one after enable). A change made in the middle of a cycle leaves that cycle's length unchanged and sets the length of the following cycle.
- R6: While en_i is low, pulse_o is low and all counting state is cleared. After the first rising clock edge that samples en_i high, the first pulse appears M*N + A clocks later, counting that edge's resulting state as clock 1.
- R7: While rst_ni is low, pulse_o is low.
- R8: The division holds at the range corners N = 3 and N = 2047, and at A = 127 (N is 11-bit binary with a legal range of 3 to 2047; A is 7-bit binary).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low selects power-save |
| n_i | input | N_W | Main count N |
| a_i | input | A_W | Swallow count A |
| msel_i | input | 1 | Modulus select: 1 picks the small pair, 0 the large pair |
| pulse_o | output | 1 | One-clock pulse at the end of each output cycle |

## Verification
Some properties are checked on every cycle: the pulse is one clock wide, the output is quiet in reset and right after a disabled clock, the active modulus register moves only at a cycle boundary, the prescaler count stays below the larger modulus plus one, the main counter never sits at zero while running, and the swallow count stays at zero once spent. The exact spacing M*N + A can only be shown by the bench scenarios. The same holds for the one-cycle delay before a mid-cycle change takes effect and the length of the first cycle after enable. The bench measures these at the output against ratios it computes itself, in both bands and at the range corners.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int unsigned N_WIDTH = 11;
  localparam int unsigned A_WIDTH = 7;

  // prescaler base modulus per band and select
  function automatic int unsigned base_mod(input bit high_band, input bit msel);
    if (high_band) return msel ? 64 : 128;
    return msel ? 8 : 16;
  endfunction
endpackage

// File: rtl/pswallow_cfg.sv
module pswallow_cfg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic load_i,
  input  logic msel_i,
  output logic start_o,
  output logic msel_o
);
  logic start_q, msel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b1;
      msel_q  <= 1'b0;
    end else if (!en_i) begin
      start_q <= 1'b1;
    end else begin
      start_q <= 1'b0;
      if (load_i) msel_q <= msel_i;
    end
  end

  assign start_o = start_q;
  assign msel_o  = msel_q;

  // R5: active modulus only moves on a boundary load
  p_cfg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(msel_q));
endmodule

// File: rtl/pswallow_presc.sv
module pswallow_presc #(
  parameter int unsigned PW      = 5,
  parameter int unsigned M_SMALL = 8,
  parameter int unsigned M_LARGE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic reload_i,
  input  logic msel_i,
  input  logic hi_i,
  output logic end_o
);
  localparam logic [PW-1:0] MS = PW'(M_SMALL);
  localparam logic [PW-1:0] ML = PW'(M_LARGE);

  logic [PW-1:0] cnt_q, base, len_m1;

  // period length is M+1 while swallowing, else M
  assign base   = msel_i ? MS : ML;
  assign len_m1 = hi_i ? base : base - 1'b1;
  assign end_o  = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (reload_i) cnt_q <= len_m1;
    else               cnt_q <= cnt_q - 1'b1;
  end

  // R2: count never exceeds the larger modulus
  p_len_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ML);
endmodule

// File: rtl/pswallow_ctr.sv
module pswallow_ctr #(
  parameter int unsigned N_W = 11,
  parameter int unsigned A_W = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           start_i,
  input  logic           pre_end_i,
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  output logic           cyc_end_o,
  output logic           boundary_o,
  output logic           hi_next_o
);
  logic [N_W-1:0] main_q;
  logic [A_W-1:0] swl_q, swl_dec;

  assign cyc_end_o  = en_i & ~start_i & pre_end_i & (main_q == N_W'(1));
  assign boundary_o = en_i & (start_i | cyc_end_o);
  assign swl_dec    = (swl_q != '0) ? swl_q - 1'b1 : swl_q;
  assign hi_next_o  = boundary_o ? (a_i != '0) : (swl_dec != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= '0;
      swl_q  <= '0;
    end else if (!en_i) begin
      main_q <= '0;
      swl_q  <= '0;
    end else if (boundary_o) begin
      main_q <= n_i;
      swl_q  <= a_i;
    end else if (pre_end_i) begin
      main_q <= main_q - 1'b1;
      swl_q  <= swl_dec;
    end
  end

  // R1: main counter is live whenever a cycle runs
  p_main_live_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_i) |-> (main_q != '0));

  // R3: once the swallow count is spent it stays spent within the cycle
  p_swallow_spent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !boundary_o && swl_q == '0) |=> (swl_q == '0));
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter bit          HIGH_BAND = 1'b0,
  parameter int unsigned N_W       = N_WIDTH,
  parameter int unsigned A_W       = A_WIDTH
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  input  logic           msel_i,
  output logic           pulse_o
);
  localparam int unsigned M_SMALL = base_mod(HIGH_BAND, 1'b1);
  localparam int unsigned M_LARGE = base_mod(HIGH_BAND, 1'b0);
  localparam int unsigned PW      = $clog2(M_LARGE + 1);

  logic start, msel_q, pre_end, cyc_end, boundary, hi_next, msel_eff;

  pswallow_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .load_i  (boundary),
    .msel_i  (msel_i),
    .start_o (start),
    .msel_o  (msel_q)
  );

  pswallow_ctr #(.N_W(N_W), .A_W(A_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .start_i    (start),
    .pre_end_i  (pre_end),
    .n_i        (n_i),
    .a_i        (a_i),
    .cyc_end_o  (cyc_end),
    .boundary_o (boundary),
    .hi_next_o  (hi_next)
  );

  // new cycle takes the modulus from the port, else the held one
  assign msel_eff = boundary ? msel_i : msel_q;

  pswallow_presc #(.PW(PW), .M_SMALL(M_SMALL), .M_LARGE(M_LARGE)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .reload_i (start | pre_end),
    .msel_i   (msel_eff),
    .hi_i     (hi_next),
    .end_o    (pre_end)
  );

  assign pulse_o = cyc_end;

  p_one_wide_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  p_quiet_after_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !pulse_o);

  p_reset_quiet_r7: assert property (@(posedge clk_i)
    !rst_ni |-> !pulse_o);
endmodule

// File: tb/pswallow_div_tb.sv
module pswallow_div_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [10:0] n_i = 11'd3;
  logic [6:0]  a_i = 7'd0;
  logic        msel_i = 1'b1;
  logic        p_lo, p_hi;
  int          checks = 0;
  int          errors = 0;

  always #10 clk_i = ~clk_i;

  pswallow_div #(.HIGH_BAND(1'b0)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .n_i(n_i), .a_i(a_i),
    .msel_i(msel_i), .pulse_o(p_lo));

  pswallow_div #(.HIGH_BAND(1'b1)) u_dut_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .n_i(n_i), .a_i(a_i),
    .msel_i(msel_i), .pulse_o(p_hi));

  function automatic int ratio(input bit hb, input bit ms, input int n, input int a);
    int m;
    if (hb) m = ms ? 64 : 128;
    else    m = ms ? 8 : 16;
    return m * n + a;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pick(input bit hb);
    return hb ? p_hi : p_lo;
  endfunction

  // clocks until next pulse; flags a wide pulse on the first clock
  task automatic count_to_pulse(input bit hb, output int c, output bit wide);
    c = 0;
    wide = 1'b0;
    do begin
      @(negedge clk_i);
      c++;
      if (c == 1 && pick(hb) && hb == hb) wide = 1'b1;
    end while (!pick(hb));
  endtask

  task automatic set_cfg(input int n, input int a, input bit ms);
    n_i = 11'(n);
    a_i = 7'(a);
    msel_i = ms;
  endtask

  // restart via enable, check first cycle then one steady interval
  task automatic restart_measure(input bit hb, input int n, input int a, input bit ms,
                                 input string tag);
    int c, exp;
    bit w, was_pulse;
    exp = ratio(hb, ms, n, a);
    @(negedge clk_i);
    set_cfg(n, a, ms);
    en_i = 1'b0;
    @(negedge clk_i);
    en_i = 1'b1;
    count_to_pulse(hb, c, w);
    check(c == exp, {tag, " R6 first cycle"}, c, exp);
    c = 0;
    was_pulse = 1'b0;
    do begin
      @(negedge clk_i);
      c++;
      if (c == 1) was_pulse = pick(hb);
    end while (!pick(hb));
    check(!was_pulse, {tag, " R4 width"}, int'(was_pulse), 0);
    check(c == exp, {tag, " interval"}, c, exp);
  endtask

  initial begin
    int c, old_p, new_p, viol, n, a;
    bit w, ms;
    void'($urandom(32'd20240611));

    // R7: quiet in reset
    repeat (3) @(negedge clk_i);
    check(!p_lo && !p_hi, "R7 reset state", int'(p_lo | p_hi), 0);
    rst_ni = 1'b1;

    // R2: high band directed and random
    restart_measure(1'b1, 3, 2, 1'b1, "R2 hi N3 A2 m64");
    restart_measure(1'b1, 20, 19, 1'b0, "R2 hi N20 A19 m128");
    for (int i = 0; i < 4; i++) begin
      n  = 3 + int'($urandom_range(0, 57));
      a  = int'($urandom_range(0, n - 1));
      ms = 1'($urandom_range(0, 1));
      restart_measure(1'b1, n, a, ms, "R2 hi random");
    end

    // R1/R3/R8: low band corners
    restart_measure(1'b0, 3, 0, 1'b1, "R8 R3 N3 A0 m8");
    restart_measure(1'b0, 3, 2, 1'b0, "R8 R3 N3 A2 m16");
    restart_measure(1'b0, 200, 127, 1'b0, "R8 A127 m16");
    restart_measure(1'b0, 2047, 127, 1'b1, "R8 N2047 A127 m8");
    restart_measure(1'b0, 2047, 0, 1'b1, "R8 R3 N2047 A0 m8");

    // R1: low band random
    for (int i = 0; i < 6; i++) begin
      n  = 3 + int'($urandom_range(0, 297));
      a  = int'($urandom_range(0, (n - 1 > 127) ? 127 : n - 1));
      ms = 1'($urandom_range(0, 1));
      restart_measure(1'b0, n, a, ms, "R1 lo random");
    end

    // R5: mid-cycle change keeps the running cycle, sets the next
    restart_measure(1'b0, 20, 5, 1'b1, "R5 base");
    old_p = ratio(1'b0, 1'b1, 20, 5);
    new_p = ratio(1'b0, 1'b0, 30, 2);
    c = 0;
    repeat (10) begin @(negedge clk_i); c++; end
    set_cfg(30, 2, 1'b0);
    while (!p_lo) begin @(negedge clk_i); c++; end
    check(c == old_p, "R5 running cycle unchanged", c, old_p);
    count_to_pulse(1'b0, c, w);
    check(c == new_p, "R5 next cycle uses new values", c, new_p);

    // R6: disable mid-cycle keeps output low, restart from zero
    repeat (37) @(negedge clk_i);
    en_i = 1'b0;
    viol = 0;
    repeat (400) begin
      @(negedge clk_i);
      if (p_lo || p_hi) viol++;
    end
    check(viol == 0, "R6 quiet while disabled", viol, 0);
    en_i = 1'b1;
    count_to_pulse(1'b0, c, w);
    check(c == new_p, "R6 restart from zero", c, new_p);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule